// File: doc/BRIEF.md
# Serial Flash Write-Permission Gate

This block sits between an instruction decoder and the program/erase engine of a serial non-volatile memory. For every decoded instruction strobe it returns a same-cycle verdict, `grant` or `reject`, and it keeps the state that drives that verdict: a write-enable latch, a status-register lock bit and a two-bit protected-region code. It also tracks whether an operation is running and whether the part is in its low-power state. All of this is visible through an eight-bit status byte.

A small state machine controls the block.

- **LOCK** is entered whenever `pwr_good` is low. It holds while a lockout counter runs for `LOCK_CYC` cycles after `pwr_good` rises.
- **LOCK** moves to **IDLE** on the edge that ends the last lockout cycle (the *expire* transition).
- **IDLE** moves to **BUSY** when a program, erase or status write is granted (the *start* transition).
- **BUSY** returns to **IDLE** on `op_done` (the *finish* transition).
- **IDLE** moves to **SLEEP** when a power-down is granted (the *doze* transition).
- **SLEEP** returns to **IDLE** when a release is granted (the *wake* transition).

The decoder presents at most one strobe per cycle.

Top module: `wp_gate`

## Requirements
- R1: While `pwr_good` is low, every strobe is rejected. One edge later, the status byte reads 0x00.
- R2: After `pwr_good` rises, write enable, program, sector erase, bulk erase and status write are rejected in the first `LOCK_CYC` clock cycles and accepted from cycle `LOCK_CYC`+1 on. Write disable is accepted during lockout.
- R3: The write-enable latch (status bit 1) is 0 after power-up and is set by a granted write enable. Program, sector erase, bulk erase and status write are granted only while the latch is 1.
- R4: Status bit 0 (busy) is 1 from the edge that grants program, sector erase, bulk erase or status write until the edge on which `op_done` is seen. That same edge clears the write-enable latch. `op_done` outside the busy period changes nothing.
- R5: A status write is rejected when `wp_n` is low and status bit 7 (register lock) is 1. A granted status write loads `new_srp` into bit 7 and `new_bp` into bits 3:2.
- R6: Program and sector erase are rejected when the address lies in the region protected by bits 3:2:
  - code 0 protects nothing;
  - code 1 protects the top quarter of the address space;
  - code 2 protects the top half;
  - code 3 protects the whole space.
- R7: Bulk erase is rejected whenever bits 3:2 are non-zero.
- R8: After a granted power-down, every strobe except release is rejected. A granted release restores normal decisions.
- R9: A granted write disable clears the write-enable latch. A rejected instruction leaves the latch unchanged.
- R10: During busy, every strobe is rejected. In a cycle with a strobe, exactly one of `grant` and `reject` is high. With no strobe, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply above threshold; low holds the block in reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write enable strobe |
| cmd_wrdi | input | 1 | Write disable strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_sect | input | 1 | Sector erase strobe |
| cmd_bulk | input | 1 | Bulk erase strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_pdown | input | 1 | Power-down strobe |
| cmd_wake | input | 1 | Release from power-down strobe |
| op_done | input | 1 | One-cycle pulse when the running operation ends |
| addr | input | ADDR_W | Target address of program or sector erase |
| new_srp | input | 1 | Register lock value carried by a status write |
| new_bp | input | 2 | Region code carried by a status write |
| grant | output | 1 | Strobe accepted (combinational) |
| reject | output | 1 | Strobe refused (combinational) |
| status | output | 8 | {lock, 3'b0, region[1:0], latch, busy} |

## Verification
A wrong state register shows as a wrong verdict on the very next strobe: for example, a machine stuck in LOCK or BUSY rejects a write enable that should pass. The same fault also appears in the status byte one edge after the instruction that should have moved it. The lockout is swept cycle by cycle across its boundary, so a counter off by one flips the verdict in exactly one cycle. The region decode is checked against every address for every code, so a wrong comparison constant shows up as a granted write inside the protected range.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_BUSY  = 2'd2,
        ST_SLEEP = 2'd3
    } wp_state_e;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic prog;
        logic sect;
        logic bulk;
        logic wrsr;
        logic pdown;
        logic wake;
    } wp_cmd_t;

    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_REG  = 2;
    localparam int SB_LOCK = 7;

endpackage

// File: rtl/wp_lockout.sv
module wp_lockout #(
    parameter int LOCK_CYC = 1000
) (
    input  logic clk,
    input  logic pwr_good,
    output logic expire
);
    localparam int CNT_W = $clog2(LOCK_CYC) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wp_region.sv
module wp_region #(
    parameter int ADDR_W = 24
) (
    input  logic [1:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};

    always_comb begin
        unique case (code)
            2'd0:    locked = 1'b0;
            2'd1:    locked = (addr >= QTR_BASE);
            2'd2:    locked = (addr >= HALF_BASE);
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_verdict.sv
module wp_verdict
    import wp_pkg::*;
(
    input  wp_state_e st,
    input  wp_cmd_t   cmd,
    input  logic      wel,
    input  logic      srp,
    input  logic [1:0] code,
    input  logic      wp_n,
    input  logic      locked,
    output logic      ok
);
    logic sr_frozen;
    assign sr_frozen = srp & ~wp_n;

    always_comb begin
        unique case (st)
            ST_LOCK:  ok = cmd.wrdi;
            ST_IDLE:  ok = cmd.wren | cmd.wrdi | cmd.pdown | cmd.wake
                         | ((cmd.prog | cmd.sect) & wel & ~locked)
                         | (cmd.bulk & wel & (code == 2'd0))
                         | (cmd.wrsr & wel & ~sr_frozen);
            ST_BUSY:  ok = 1'b0;
            ST_SLEEP: ok = cmd.wake;
            default:  ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LOCK_CYC = 1000
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_prog,
    input  logic              cmd_sect,
    input  logic              cmd_bulk,
    input  logic              cmd_wrsr,
    input  logic              cmd_pdown,
    input  logic              cmd_wake,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] addr,
    input  logic              new_srp,
    input  logic [1:0]        new_bp,
    output logic              grant,
    output logic              reject,
    output logic [7:0]        status
);
    wp_state_e  state, state_nx;
    wp_cmd_t    cmd;
    logic       wel, srp;
    logic [1:0] code;
    logic       lock_expire, locked, ok, any_cmd, starts_op;

    assign cmd = '{wren: cmd_wren, wrdi: cmd_wrdi, prog: cmd_prog,
                   sect: cmd_sect, bulk: cmd_bulk, wrsr: cmd_wrsr,
                   pdown: cmd_pdown, wake: cmd_wake};

    wp_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
        .clk      (clk),
        .pwr_good (pwr_good),
        .expire   (lock_expire)
    );

    wp_region #(.ADDR_W(ADDR_W)) u_region (
        .code   (code),
        .addr   (addr),
        .locked (locked)
    );

    wp_verdict u_verdict (
        .st     (state),
        .cmd    (cmd),
        .wel    (wel),
        .srp    (srp),
        .code   (code),
        .wp_n   (wp_n),
        .locked (locked),
        .ok     (ok)
    );

    assign any_cmd   = |cmd;
    assign grant     = pwr_good & any_cmd & ok;
    assign reject    = any_cmd & ~grant;
    assign starts_op = grant & (cmd.prog | cmd.sect | cmd.bulk | cmd.wrsr);

    // State register
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            state <= ST_LOCK;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: expire, start, finish, doze, wake
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCK:  if (lock_expire) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (starts_op)                 state_nx = ST_BUSY;
                else if (grant && cmd.pdown)   state_nx = ST_SLEEP;
            end
            ST_BUSY:  if (op_done) state_nx = ST_IDLE;
            ST_SLEEP: if (grant && cmd.wake) state_nx = ST_IDLE;
            default:  state_nx = ST_LOCK;
        endcase
    end

    // Latch, lock bit and region code
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            wel  <= 1'b0;
            srp  <= 1'b0;
            code <= 2'd0;
        end else begin
            if (state == ST_BUSY && op_done) begin
                wel <= 1'b0;
            end else if (grant && cmd.wren) begin
                wel <= 1'b1;
            end else if (grant && cmd.wrdi) begin
                wel <= 1'b0;
            end
            if (grant && cmd.wrsr) begin
                srp  <= new_srp;
                code <= new_bp;
            end
        end
    end

    always_comb begin
        status                     = 8'h00;
        status[SB_BUSY]            = (state == ST_BUSY);
        status[SB_WEL]             = wel;
        status[SB_REG+1:SB_REG]    = code;
        status[SB_LOCK]            = srp;
    end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk (
    input logic       clk,
    input logic       pwr_good,
    input logic       wp_n,
    input logic       cmd_prog,
    input logic       cmd_sect,
    input logic       cmd_bulk,
    input logic       cmd_wrsr,
    input logic       op_done,
    input logic       grant,
    input logic       reject,
    input logic [7:0] status
);
    // R1
    pg_low_chk: assert property (@(posedge clk) !pwr_good |-> !grant);

    // R3
    wel_needed_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (grant && (cmd_prog || cmd_sect || cmd_bulk || cmd_wrsr)) |-> status[1]);

    // R4
    wel_clear_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (status[0] && op_done) |=> !status[1]);

    // R5
    srp_lock_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (cmd_wrsr && !wp_n && status[7]) |-> !grant);

    // R7
    bulk_guard_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (cmd_bulk && status[3:2] != 2'b00) |-> !grant);

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        status[0] |-> !grant);

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !(grant && reject));
endmodule

bind wp_gate wp_gate_chk u_wp_gate_chk (
    .clk      (clk),
    .pwr_good (pwr_good),
    .wp_n     (wp_n),
    .cmd_prog (cmd_prog),
    .cmd_sect (cmd_sect),
    .cmd_bulk (cmd_bulk),
    .cmd_wrsr (cmd_wrsr),
    .op_done  (op_done),
    .grant    (grant),
    .reject   (reject),
    .status   (status)
);

// File: tb/wp_gate_bench.sv
module wp_gate_bench;
    localparam int AW  = 6;
    localparam int LC  = 6;
    localparam int N   = 1 << AW;

    localparam int C_WREN  = 0;
    localparam int C_WRDI  = 1;
    localparam int C_PROG  = 2;
    localparam int C_SECT  = 3;
    localparam int C_BULK  = 4;
    localparam int C_WRSR  = 5;
    localparam int C_PDOWN = 6;
    localparam int C_WAKE  = 7;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic wp_n = 1'b1;
    logic c_wren = 0, c_wrdi = 0, c_prog = 0, c_sect = 0;
    logic c_bulk = 0, c_wrsr = 0, c_pdown = 0, c_wake = 0;
    logic op_done = 1'b0;
    logic [AW-1:0] addr = '0;
    logic new_srp = 1'b0;
    logic [1:0] new_bp = 2'd0;
    logic grant, reject;
    logic [7:0] status;

    int n_chk = 0;
    int n_err = 0;
    logic g, r;

    always #5 clk = ~clk;

    wp_gate #(.ADDR_W(AW), .LOCK_CYC(LC)) u_wp_gate (
        .clk(clk), .pwr_good(pwr_good), .wp_n(wp_n),
        .cmd_wren(c_wren), .cmd_wrdi(c_wrdi), .cmd_prog(c_prog),
        .cmd_sect(c_sect), .cmd_bulk(c_bulk), .cmd_wrsr(c_wrsr),
        .cmd_pdown(c_pdown), .cmd_wake(c_wake), .op_done(op_done),
        .addr(addr), .new_srp(new_srp), .new_bp(new_bp),
        .grant(grant), .reject(reject), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input int c, input logic [AW-1:0] a,
                         output logic go, output logic no);
        @(negedge clk);
        addr = a;
        case (c)
            C_WREN:  c_wren  = 1'b1;
            C_WRDI:  c_wrdi  = 1'b1;
            C_PROG:  c_prog  = 1'b1;
            C_SECT:  c_sect  = 1'b1;
            C_BULK:  c_bulk  = 1'b1;
            C_WRSR:  c_wrsr  = 1'b1;
            C_PDOWN: c_pdown = 1'b1;
            default: c_wake  = 1'b1;
        endcase
        #1;
        go = grant;
        no = reject;
        @(posedge clk);
        #1;
        {c_wren, c_wrdi, c_prog, c_sect, c_bulk, c_wrsr, c_pdown, c_wake} = '0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(posedge clk);
        #1;
        op_done = 1'b0;
    endtask

    // Places the caller so that the next issue lands in cycle j after pwr_good rises
    task automatic power_up(input int j);
        @(negedge clk);
        pwr_good = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        pwr_good = 1'b1;
        for (int k = 1; k < j; k++) @(posedge clk);
    endtask

    task automatic set_region(input logic lk, input logic [1:0] bp);
        issue(C_WREN, '0, g, r);
        new_srp = lk;
        new_bp  = bp;
        issue(C_WRSR, '0, g, r);
        chk("R5 status write accepted", int'(g), 1);
        finish_op();
    endtask

    function automatic bit in_region(input int bp, input int a);
        if (bp == 0) return 1'b0;
        if (bp == 1) return a >= (3 * N) / 4;
        if (bp == 2) return a >= N / 2;
        return 1'b1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: held low
        repeat (3) @(posedge clk);
        issue(C_WREN, '0, g, r);
        chk("R1 grant while supply low", int'(g), 0);
        chk("R1 reject while supply low", int'(r), 1);
        chk("R1 status while supply low", int'(status), 8'h00);

        // R2: lockout boundary, cycle by cycle
        for (int j = 1; j <= LC + 1; j++) begin
            power_up(j);
            issue(C_WREN, '0, g, r);
            chk("R2 write enable at lockout cycle", int'(g), (j > LC) ? 1 : 0);
            chk("R3 latch after lockout probe", int'(status[1]), (j > LC) ? 1 : 0);
        end
        power_up(1);
        issue(C_WRDI, '0, g, r);
        chk("R2 write disable during lockout", int'(g), 1);
        issue(C_PROG, '0, g, r);
        chk("R2 program during lockout", int'(g), 0);

        power_up(LC + 1);
        // R3 / R9
        chk("R3 latch zero after power-up", int'(status), 8'h00);
        issue(C_PROG, '0, g, r);
        chk("R3 program without latch", int'(g), 0);
        chk("R9 latch unchanged after reject", int'(status[1]), 0);
        issue(C_WREN, '0, g, r);
        chk("R3 status after write enable", int'(status), 8'h02);
        issue(C_WRDI, '0, g, r);
        chk("R9 write disable clears latch", int'(status), 8'h00);

        // R4 / R10
        issue(C_WREN, '0, g, r);
        issue(C_PROG, 6'd5, g, r);
        chk("R3 program with latch", int'(g), 1);
        chk("R4 busy and latch during op", int'(status), 8'h03);
        issue(C_WREN, '0, g, r);
        chk("R10 reject while busy", int'(r), 1);
        chk("R10 no grant while busy", int'(g), 0);
        finish_op();
        chk("R4 done clears busy and latch", int'(status), 8'h00);
        issue(C_WREN, '0, g, r);
        finish_op();
        chk("R4 done outside busy ignored", int'(status), 8'h02);
        issue(C_WRDI, '0, g, r);

        // R10 idle verdicts
        @(negedge clk);
        chk("R10 no strobe no grant", int'(grant), 0);
        chk("R10 no strobe no reject", int'(reject), 0);

        // R5
        issue(C_WREN, '0, g, r);
        new_srp = 1'b1;
        new_bp  = 2'd0;
        issue(C_WRSR, '0, g, r);
        chk("R5 status write loads fields", int'(status), 8'h83);
        finish_op();
        chk("R5 after status write", int'(status), 8'h80);
        wp_n = 1'b0;
        issue(C_WREN, '0, g, r);
        issue(C_WRSR, '0, g, r);
        chk("R5 locked status write", int'(g), 0);
        chk("R9 latch kept after reject", int'(status), 8'h82);
        wp_n = 1'b1;
        new_srp = 1'b0;
        issue(C_WRSR, '0, g, r);
        chk("R5 pin high allows write", int'(g), 1);
        finish_op();
        chk("R5 lock cleared", int'(status), 8'h00);

        // R6 / R7: every code, every address
        for (int bp = 0; bp < 4; bp++) begin
            set_region(1'b0, 2'(bp));
            chk("R5 region code loaded", int'(status[3:2]), bp);
            for (int a = 0; a < N; a++) begin
                for (int c = C_PROG; c <= C_SECT; c++) begin
                    issue(C_WREN, '0, g, r);
                    issue(c, AW'(a), g, r);
                    chk("R6 region verdict", int'(g), in_region(bp, a) ? 0 : 1);
                    if (g) finish_op();
                end
            end
            issue(C_WREN, '0, g, r);
            issue(C_BULK, '0, g, r);
            chk("R7 bulk erase verdict", int'(g), (bp == 0) ? 1 : 0);
            if (g) finish_op();
            issue(C_WRDI, '0, g, r);
        end
        set_region(1'b0, 2'd0);

        // R8
        issue(C_PDOWN, '0, g, r);
        chk("R8 power-down accepted", int'(g), 1);
        issue(C_WREN, '0, g, r);
        chk("R8 write enable while down", int'(g), 0);
        issue(C_WRDI, '0, g, r);
        chk("R8 write disable while down", int'(g), 0);
        issue(C_WAKE, '0, g, r);
        chk("R8 release accepted", int'(g), 1);
        issue(C_WREN, '0, g, r);
        chk("R8 write enable after release", int'(g), 1);

        // R1 again: supply drop clears everything
        @(negedge clk);
        pwr_good = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 status cleared on supply drop", int'(status), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule